// File: doc/BRIEF.md
# Notification Ring Page-Directory Setup Walker

This block locates a notification ring in host memory before the ring is used. Software hands it the address of a page directory and the number of pages that back the ring, then pulses a start input. The walker reads directory entry 0 to learn where the page table sits. It then reads table entry 0 to learn where the ring-state page sits. Table entries 1 and up describe the data pages.

When both reads succeed, the walker reports three results. The first is the address of the state record this ring owns, which is the second record on the state page. The second is a pointer to the first data-page entry of the table. The third is the ring capacity in entries. A one-cycle done pulse marks the end of a good setup.

A page count of zero, or a failed read at either level, ends the setup with a one-cycle error pulse instead. In that case the result outputs read zero. Reads go out over a simple request/response port: a one-cycle request with an address, and later a one-cycle response carrying 64-bit data and an error bit.

Top module: `ring_dir_walker`

## Requirements
- R1: A start with a page count of zero raises the error pulse in the cycle after the start is sampled, and no read request is issued for that setup.
- R2: The first read request of a setup carries the directory address exactly as given at start, which is directory entry 0.
- R3: The second read request carries the 64-bit value returned by the first read, which is table entry 0.
- R4: After a good setup, the state address output equals the value returned by the second read plus the state-record size (default 64 bytes).
- R5: After a good setup, the data-base output equals the table address plus 8, which is the byte address of table entry 1.
- R6: After a good setup, the capacity output equals (page count − 1) × page size ÷ entry size. With the defaults this is (count − 1) × 256, so a count of 1 gives 0.
- R7: A response with its error bit set, at either stage, raises the error pulse in the next cycle. No further read is issued, and all result outputs read zero.
- R8: The done pulse appears in the cycle after the table response is sampled. Done and error each last exactly one cycle and are never high together.
- R9: A start pulse that arrives while a setup is in progress is ignored: it changes neither the reads issued nor the results.
- R10: All result outputs are zero after reset. They are cleared to zero when a start is accepted, and they hold the last good results until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | One-cycle pulse that begins a setup |
| dirAddrIn | input | ADDR_W | Byte address of the page directory |
| pageCountIn | input | CNT_W | Number of pages that back the ring |
| rdReqOut | output | 1 | One-cycle read request |
| rdAddrOut | output | ADDR_W | Address of the 64-bit read |
| rdRespValid | input | 1 | One-cycle read response strobe |
| rdRespData | input | 64 | Read response data |
| rdRespErr | input | 1 | Read failed, qualified by rdRespValid |
| stateAddrOut | output | ADDR_W | Address of this ring's state record |
| dataBaseOut | output | ADDR_W | Address of the first data-page table entry |
| capacityOut | output | CAP_W | Ring capacity in entries |
| setupDone | output | 1 | One-cycle pulse on a good setup |
| setupErr | output | 1 | One-cycle pulse on a failed setup |

## Verification
Every result appears at a fixed cycle. A read request comes out one cycle after the start, or after the directory response, is sampled. Done or error follows one cycle after the deciding event, whether that is the table response, a faulty response, or a zero-count start.

The bench keeps a cycle counter in its memory model and records the cycle of each response it drives. It samples the outputs just after the falling edge and compares the cycle of each done or error pulse against the recorded cycle plus one. It also checks that the pulse is gone one cycle later.

The model is run with response latencies of one and three cycles, so the fixed offset is checked under both.

// File: rtl/ring_walk_pkg.sv
package ring_walk_pkg;

  // bytes per directory or table entry
  localparam int unsigned PTR_BYTES = 8;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_READ_DIR,
    WK_READ_TBL,
    WK_DONE,
    WK_ERROR
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // accepted start: capture inputs, clear results
    logic takeTbl;  // directory entry arrived: keep table address
    logic commit;   // table entry arrived: publish results
    logic wipe;     // failure: clear results
    logic pickTbl;  // read address selects the table
  } walkStrb_t;

endpackage

// File: rtl/ring_walk_ctrl.sv
module ring_walk_ctrl
  import ring_walk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      countZero,
  input  logic      rspValid,
  input  logic      rspErr,
  output walkStrb_t strb,
  output logic      rdReqOut,
  output logic      doneOut,
  output logic      errOut
);

  walkState_t stateQ, stateD;
  logic reqQ, reqD;
  logic acceptGood, acceptZero, dirOk, tblOk, rspBad;

  assign acceptGood = (stateQ == WK_IDLE) && startIn && !countZero;
  assign acceptZero = (stateQ == WK_IDLE) && startIn && countZero;
  assign dirOk      = (stateQ == WK_READ_DIR) && rspValid && !rspErr;
  assign tblOk      = (stateQ == WK_READ_TBL) && rspValid && !rspErr;
  assign rspBad     = ((stateQ == WK_READ_DIR) || (stateQ == WK_READ_TBL))
                      && rspValid && rspErr;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      WK_IDLE:     if (acceptZero) stateD = WK_ERROR;
                   else if (acceptGood) stateD = WK_READ_DIR;
      WK_READ_DIR: if (rspBad) stateD = WK_ERROR;
                   else if (dirOk) stateD = WK_READ_TBL;
      WK_READ_TBL: if (rspBad) stateD = WK_ERROR;
                   else if (tblOk) stateD = WK_DONE;
      WK_DONE:     stateD = WK_IDLE;
      WK_ERROR:    stateD = WK_IDLE;
      default:     stateD = WK_IDLE;
    endcase
  end

  assign reqD = acceptGood || dirOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= WK_IDLE;
      reqQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      reqQ   <= reqD;
    end
  end

  always_comb begin
    strb.load    = acceptGood || acceptZero;
    strb.takeTbl = dirOk;
    strb.commit  = tblOk;
    strb.wipe    = rspBad;
    strb.pickTbl = (stateQ == WK_READ_TBL);
  end

  assign rdReqOut = reqQ;
  assign doneOut  = (stateQ == WK_DONE);
  assign errOut   = (stateQ == WK_ERROR);

  // R1
  zero_cnt_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptZero |=> (errOut && !rdReqOut));

  // R7
  bad_rsp_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspBad |=> (errOut && !rdReqOut && !doneOut));

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOut && errOut));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    errOut |=> !errOut);

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReqOut |=> !rdReqOut);

endmodule

// File: rtl/ring_walk_dp.sv
module ring_walk_dp
  import ring_walk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned SLOT_BYTES = 16,
  parameter int unsigned REC_BYTES  = 64,
  localparam int unsigned CAP_SHIFT = $clog2(PAGE_BYTES) - $clog2(SLOT_BYTES),
  localparam int unsigned CAP_W     = CNT_W + CAP_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrb_t         strb,
  input  logic [ADDR_W-1:0] dirAddrIn,
  input  logic [CNT_W-1:0]  pageCountIn,
  input  logic [63:0]       rspData,
  output logic              countZero,
  output logic [ADDR_W-1:0] rdAddrOut,
  output logic [ADDR_W-1:0] stateAddrOut,
  output logic [ADDR_W-1:0] dataBaseOut,
  output logic [CAP_W-1:0]  capacityOut
);

  logic [ADDR_W-1:0] dirQ, tblQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CAP_W-1:0]  capCalc;
  logic [ADDR_W-1:0] rspAddr;

  assign countZero = (pageCountIn == '0);
  assign rspAddr   = rspData[ADDR_W-1:0];
  assign capCalc   = CAP_W'(cntQ - CNT_W'(1)) << CAP_SHIFT;
  assign rdAddrOut = strb.pickTbl ? tblQ : dirQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
      tblQ <= '0;
      cntQ <= '0;
    end else begin
      if (strb.load) begin
        dirQ <= dirAddrIn;
        cntQ <= pageCountIn;
      end
      if (strb.takeTbl) tblQ <= rspAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateAddrOut <= '0;
      dataBaseOut  <= '0;
      capacityOut  <= '0;
    end else if (strb.load || strb.wipe) begin
      stateAddrOut <= '0;
      dataBaseOut  <= '0;
      capacityOut  <= '0;
    end else if (strb.commit) begin
      stateAddrOut <= rspAddr + ADDR_W'(REC_BYTES);
      dataBaseOut  <= tblQ + ADDR_W'(PTR_BYTES);
      capacityOut  <= capCalc;
    end
  end

  // R7
  wipe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wipe |=> (stateAddrOut == '0 && dataBaseOut == '0 && capacityOut == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.wipe || strb.commit) |=> $stable(capacityOut));

endmodule

// File: rtl/ring_dir_walker.sv
module ring_dir_walker
  import ring_walk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned SLOT_BYTES = 16,
  parameter int unsigned REC_BYTES  = 64,
  localparam int unsigned CAP_W = CNT_W + $clog2(PAGE_BYTES) - $clog2(SLOT_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [ADDR_W-1:0] dirAddrIn,
  input  logic [CNT_W-1:0]  pageCountIn,
  output logic              rdReqOut,
  output logic [ADDR_W-1:0] rdAddrOut,
  input  logic              rdRespValid,
  input  logic [63:0]       rdRespData,
  input  logic              rdRespErr,
  output logic [ADDR_W-1:0] stateAddrOut,
  output logic [ADDR_W-1:0] dataBaseOut,
  output logic [CAP_W-1:0]  capacityOut,
  output logic              setupDone,
  output logic              setupErr
);

  walkStrb_t strb;
  logic      countZero;

  ring_walk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .countZero (countZero),
    .rspValid  (rdRespValid),
    .rspErr    (rdRespErr),
    .strb      (strb),
    .rdReqOut  (rdReqOut),
    .doneOut   (setupDone),
    .errOut    (setupErr)
  );

  ring_walk_dp #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .PAGE_BYTES (PAGE_BYTES),
    .SLOT_BYTES (SLOT_BYTES),
    .REC_BYTES  (REC_BYTES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .dirAddrIn    (dirAddrIn),
    .pageCountIn  (pageCountIn),
    .rspData      (rdRespData),
    .countZero    (countZero),
    .rdAddrOut    (rdAddrOut),
    .stateAddrOut (stateAddrOut),
    .dataBaseOut  (dataBaseOut),
    .capacityOut  (capacityOut)
  );

endmodule

// File: tb/ring_dir_walker_tb.sv
module ring_dir_walker_tb;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [63:0] dirAddrIn = '0;
  logic [15:0] pageCountIn = '0;
  logic        rdReqOut;
  logic [63:0] rdAddrOut;
  logic        rdRespValid = 1'b0;
  logic [63:0] rdRespData = '0;
  logic        rdRespErr = 1'b0;
  logic [63:0] stateAddrOut, dataBaseOut;
  logic [23:0] capacityOut;
  logic        setupDone, setupErr;

  int checks = 0;
  int errors = 0;

  // memory model state
  int          cyc = 0;
  int          respLat = 1;
  int          errStage = 0;
  int          reqCount = 0;
  int          lastRespCyc = -1;
  logic [63:0] reqAddr [0:3];
  logic [63:0] mDir = '0, mTbl = '0, mSt = '0;
  bit          pend = 0;
  int          waitCnt = 0;
  logic [63:0] pendAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_dir_walker u_dut (
    .clk (clk), .rstN (rstN), .startIn (startIn), .dirAddrIn (dirAddrIn),
    .pageCountIn (pageCountIn), .rdReqOut (rdReqOut), .rdAddrOut (rdAddrOut),
    .rdRespValid (rdRespValid), .rdRespData (rdRespData), .rdRespErr (rdRespErr),
    .stateAddrOut (stateAddrOut), .dataBaseOut (dataBaseOut),
    .capacityOut (capacityOut), .setupDone (setupDone), .setupErr (setupErr)
  );

  // behavioural memory: reads sampled and answered at falling edges
  always @(negedge clk) begin
    cyc = cyc + 1;
    rdRespValid = 1'b0;
    rdRespErr   = 1'b0;
    if (pend && waitCnt == 0) begin
      rdRespValid = 1'b1;
      rdRespErr   = (errStage == reqCount);
      if (pendAddr == mDir) rdRespData = mTbl;
      else if (pendAddr == mTbl) rdRespData = mSt;
      else rdRespData = 64'hBAD0_BAD0_BAD0_BAD0;
      lastRespCyc = cyc;
      pend = 0;
    end else if (pend) begin
      waitCnt = waitCnt - 1;
    end
    if (rdReqOut) begin
      if (reqCount < 4) reqAddr[reqCount] = rdAddrOut;
      reqCount = reqCount + 1;
      pend = 1;
      pendAddr = rdAddrOut;
      waitCnt = respLat - 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // run one setup; returns which flag ended it and in which cycle
  task automatic runSetup(input logic [63:0] dir, input logic [63:0] tbl,
                          input logic [63:0] st, input int cnt, input int lat,
                          input int errAt, input bit busyPoke,
                          output bit gotDone, output bit gotErr,
                          output int endCyc, output int startCyc);
    mDir = dir; mTbl = tbl; mSt = st;
    respLat = lat; errStage = errAt; reqCount = 0;
    for (int i = 0; i < 4; i++) reqAddr[i] = '0;
    gotDone = 0; gotErr = 0; endCyc = -1;
    @(negedge clk); #1;
    dirAddrIn = dir; pageCountIn = 16'(cnt); startIn = 1'b1;
    startCyc = cyc;
    @(negedge clk); #1;
    startIn = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (setupDone || setupErr) begin
        gotDone = setupDone; gotErr = setupErr; endCyc = cyc;
        break;
      end
      if (busyPoke && i == 1) begin
        dirAddrIn = 64'h7777_0000; pageCountIn = 16'd9; startIn = 1'b1;
      end else begin
        startIn = 1'b0;
      end
      @(negedge clk); #1;
    end
    startIn = 1'b0;
  endtask

  task automatic checkPulseGone(input string tag);
    @(negedge clk); #1;
    check(!setupDone && !setupErr, tag, {62'd0, setupDone, setupErr}, 64'd0);
  endtask

  task automatic testReset();
    check(rdReqOut == 1'b0, "R10 reset rdReq", 64'(rdReqOut), 64'd0);
    check(!setupDone && !setupErr, "R10 reset flags", {62'd0, setupDone, setupErr}, 64'd0);
    check(stateAddrOut == '0, "R10 reset stateAddr", stateAddrOut, 64'd0);
    check(capacityOut == '0 && dataBaseOut == '0, "R10 reset cap/base",
          dataBaseOut, 64'd0);
  endtask

  task automatic testGood(input logic [63:0] dir, input logic [63:0] tbl,
                          input logic [63:0] st, input int cnt, input int lat);
    bit d, e; int ec, sc;
    logic [63:0] expCap;
    runSetup(dir, tbl, st, cnt, lat, 0, 0, d, e, ec, sc);
    expCap = 64'((cnt - 1) * 4096 / 16);
    check(d && !e, "R8 good setup done", {62'd0, d, e}, 64'd2);
    check(ec == lastRespCyc + 1, "R8 done cycle", 64'(ec), 64'(lastRespCyc + 1));
    check(reqCount == 2, "R2 read count", 64'(reqCount), 64'd2);
    check(reqAddr[0] == dir, "R2 directory read address", reqAddr[0], dir);
    check(reqAddr[1] == tbl, "R3 table read address", reqAddr[1], tbl);
    check(stateAddrOut == st + 64'd64, "R4 state address", stateAddrOut, st + 64'd64);
    check(dataBaseOut == tbl + 64'd8, "R5 data base", dataBaseOut, tbl + 64'd8);
    check(64'(capacityOut) == expCap, "R6 capacity", 64'(capacityOut), expCap);
    checkPulseGone("R8 done single cycle");
    check(64'(capacityOut) == expCap && stateAddrOut == st + 64'd64,
          "R10 results held", 64'(capacityOut), expCap);
  endtask

  task automatic testZero();
    bit d, e; int ec, sc;
    runSetup(64'h1000, 64'h2000, 64'h3000, 0, 1, 0, 0, d, e, ec, sc);
    check(e && !d, "R1 zero count error", {62'd0, d, e}, 64'd1);
    check(ec == sc + 1, "R1 error cycle", 64'(ec), 64'(sc + 1));
    repeat (4) @(negedge clk);
    #1;
    check(reqCount == 0, "R1 no read issued", 64'(reqCount), 64'd0);
    check(stateAddrOut == '0 && capacityOut == '0, "R10 cleared by start",
          stateAddrOut, 64'd0);
    checkPulseGone("R8 error single cycle");
  endtask

  task automatic testFault(input int stage, input int lat);
    bit d, e; int ec, sc;
    runSetup(64'h0000_0004_0000_0000, 64'h0000_0000_5555_0000,
             64'h0000_0000_6666_0000, 4, lat, stage, 0, d, e, ec, sc);
    check(e && !d, "R7 fault error", {62'd0, d, e}, 64'd1);
    check(ec == lastRespCyc + 1, "R7 error cycle", 64'(ec), 64'(lastRespCyc + 1));
    repeat (4) @(negedge clk);
    #1;
    check(reqCount == stage, "R7 no further read", 64'(reqCount), 64'(stage));
    check(stateAddrOut == '0 && dataBaseOut == '0 && capacityOut == '0,
          "R7 results zero", stateAddrOut | dataBaseOut, 64'd0);
  endtask

  task automatic testBusy();
    bit d, e; int ec, sc;
    runSetup(64'h0000_0000_00AB_C000, 64'h0000_0000_00DE_F000,
             64'h0000_0000_0012_3000, 5, 3, 0, 1, d, e, ec, sc);
    check(d && !e, "R9 busy start ignored, done", {62'd0, d, e}, 64'd2);
    repeat (6) @(negedge clk);
    #1;
    check(reqCount == 2, "R9 read count", 64'(reqCount), 64'd2);
    check(reqAddr[0] == 64'h00AB_C000, "R9 first address", reqAddr[0], 64'h00AB_C000);
    check(64'(capacityOut) == 64'd1024, "R9 capacity", 64'(capacityOut), 64'd1024);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testGood(64'h0000_0001_2345_6000, 64'h0000_0000_8000_1000,
             64'h0000_0000_9ABC_D000, 3, 1);
    testGood(64'h0000_0000_0001_0000, 64'h0000_0000_0002_0000,
             64'h0000_0000_0003_0000, 1, 3);
    testGood(64'h0000_0000_0010_0000, 64'h0000_0000_0020_0000,
             64'h0000_0000_0030_0000, 65535, 2);
    testZero();
    testGood(64'h0000_0000_0A00_0000, 64'h0000_0000_0B00_0000,
             64'h0000_0000_0C00_0000, 2, 1);
    testFault(1, 1);
    testGood(64'h0000_0000_0A00_0000, 64'h0000_0000_0B00_0000,
             64'h0000_0000_0C00_0000, 2, 1);
    testFault(2, 3);
    testBusy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule